// File: doc/BRIEF.md
# Half-Word to Word Register Bridge

This bridge sits between a 16-bit host bus and the 32-bit register file of a network controller. When the static `mode16` input is high, the host may use half-word accesses. The bridge pairs two halves that fall in the same aligned word and turns them into one full-word register access. Full-word accesses pass straight through in either mode.

For writes, each half is parked in a high or a low holding register. The second half of a pair commits `{high, low}` downstream in the same cycle. For reads, the first half of a pair fetches the whole word into a latch. The second half is then answered from that latch with no downstream traffic. Reads and writes each keep their own pair counter and their own last-word address.

The bridge also owns the hardware-configuration word. A read-only bit in that word tells software which bus width the bridge was strapped to. A software reset request in that word re-arms both pair counters.

Top module: `hw2w_bridge`

## Requirements
- R1: After `rst_n` is released, the configuration word reads 0x00050004 when `mode16`=0 and 0x00050000 when `mode16`=1. Bit 2 of the configuration word always equals the inverse of `mode16`. Both pair counters start cleared.
- R2: Only bits 7:0 of `host_addr` are decoded. Every downstream access uses the word-aligned offset: `ds_addr` = {zeros, offset[7:2], 2'b00}.
- R3: `host_size` encodes the access size as 2'b01 for a half word and 2'b10 for a full word. Offset bit 1 set selects bits 31:16, and clear selects bits 15:0. Two half writes to the same aligned word produce exactly one downstream write, carrying {high holding, low holding}, in the cycle of the second half. The first half produces none.
- R4: A half write to a different aligned word than the previous half write restarts write pairing at that word. Which halves make up a pair is not checked, so two low halves commit with the older high holding value.
- R5: The first half read of a pair issues one downstream read of the aligned word and latches the result. The second half read of the same word returns the other half from the latch, with no downstream access, even if the register file has since changed.
- R6: A half read to a different aligned word than the previous half read restarts read pairing, so it fetches again.
- R7: Read and write pairing are independent. A half read between the two halves of a write pair does not break that pair, and a half write does not disturb read pairing.
- R8: Full-word accesses go directly downstream in both modes and leave both pair counters unchanged.
- R9: `host_err` pulses for one accepted cycle, with `host_ready` high, when the size is 2'b00 or 2'b11, or when a half-word access arrives while `mode16`=0. Such an access makes no downstream access and changes no counter.
- R10: The configuration word sits at offset 0x74 and is never forwarded downstream. A write there stores only the bits in mask 0x0003F300 and keeps bit 2. The word then reads back exactly as stored.
- R11: Writing the configuration word with bit 0 set is a software reset. It restores the configuration reset value and clears both pair counters.
- R12: Writes, error accesses and second-half reads complete in the cycle they are presented. An access that needs a fetch (a word read, or a first half read) raises `ds_req` in its first cycle, except at offset 0x74. `ds_rdata` is captured on the next cycle. `host_ready` rises in the third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode16 | input | 1 | Static strap: 1 = 16-bit host bus, 0 = 32-bit |
| host_req | input | 1 | Host access request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 01 = half word, 10 = full word, others invalid |
| host_addr | input | 16 | Byte offset; only bits 7:0 are decoded |
| host_wdata | input | 32 | Write data; a half write uses bits 15:0 |
| host_rdata | output | 32 | Read data; a half read returns it in bits 15:0 |
| host_ready | output | 1 | Access completes on a clock edge where this is high |
| host_err | output | 1 | Invalid access pulse |
| ds_req | output | 1 | One-cycle register file request |
| ds_we | output | 1 | Register file write enable |
| ds_addr | output | 32 | Register file word-aligned byte address |
| ds_wdata | output | 32 | Register file write data |
| ds_rdata | input | 32 | Register file read data, valid the cycle after a read request |

## Verification
The assertions check several properties on every cycle:
- the invariant part of the configuration bit, and the cleared bits outside the write mask;
- the alignment of every downstream address;
- that a commit is never followed by another commit;
- that an error pulse never coincides with downstream traffic and leaves both counters still;
- that a downstream read is always followed by a wait and then a ready response.

Only the bench scenarios show the pairing data itself:
- which word each pair commits, and the stale-latch return after a backdoor change;
- the restart when the word address moves;
- read pairing interleaved with write pairing, and pass-through words between two halves;
- the counter re-arm after a software reset.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  localparam int DW     = 32;
  localparam int HW     = DW / 2;
  localparam int PAIR_W = 2;

  typedef logic [PAIR_W-1:0] pair_t;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} bst_e;

  // Next pair count: restart at one when the word address moved.
  function automatic pair_t pair_next(input logic same, input pair_t cnt);
    return same ? pair_t'(cnt + 1'b1) : pair_t'(1);
  endfunction

  function automatic logic [HW-1:0] half_pick(input logic [DW-1:0] w, input logic upper);
    return upper ? w[DW-1:HW] : w[HW-1:0];
  endfunction

  function automatic logic [DW-1:0] cfg_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] wd,
                                               input logic [DW-1:0] wmask,
                                               input logic [DW-1:0] keep);
    return (wd & wmask) | (old_v & keep);
  endfunction

  function automatic logic [DW-1:0] cfg_reset(input logic [DW-1:0] base,
                                               input logic mode16,
                                               input int unsigned bitpos);
    return mode16 ? base : (base | (DW'(1) << bitpos));
  endfunction
endpackage

// File: rtl/hwb_wr_pair.sv
module hwb_wr_pair import hwb_pkg::*; #(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [OFF_W-1:0] woff,
  input  logic             upper,
  input  logic [HW-1:0]    wdata16,
  output logic             commit,
  output logic [DW-1:0]    commit_word,
  output pair_t            cnt_o
);
  logic [OFF_W-1:0] prev_q;
  pair_t            cnt_q;
  pair_t            nxt;
  logic [HW-1:0]    hi_q, lo_q, hi_n, lo_n;
  logic             same;

  assign same        = (woff == prev_q);
  assign nxt         = pair_next(same, cnt_q);
  assign commit      = step && (nxt == pair_t'(2));
  assign hi_n        = (step && upper)  ? wdata16 : hi_q;
  assign lo_n        = (step && !upper) ? wdata16 : lo_q;
  assign commit_word = {hi_n, lo_n};
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (step) begin
        prev_q <= woff;
        cnt_q  <= commit ? pair_t'(0) : nxt;
        hi_q   <= hi_n;
        lo_q   <= lo_n;
      end
      if (clr) cnt_q <= '0;
    end
  end

  // R3: a commit empties the pair, so two commits never come back to back
  p_one_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R4: the write counter never holds more than one pending half
  p_wr_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pair_t'(1));
endmodule

// File: rtl/hwb_rd_pair.sv
module hwb_rd_pair import hwb_pkg::*; #(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [OFF_W-1:0] woff,
  input  logic             load,
  input  logic [DW-1:0]    load_val,
  output logic             first,
  output logic [DW-1:0]    latch_o,
  output pair_t            cnt_o
);
  logic [OFF_W-1:0] prev_q;
  pair_t            cnt_q;
  pair_t            nxt;
  logic [DW-1:0]    latch_q;

  assign nxt     = pair_next(woff == prev_q, cnt_q);
  assign first   = (nxt == pair_t'(1));
  assign latch_o = latch_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cnt_q   <= '0;
      latch_q <= '0;
    end else begin
      if (step) begin
        prev_q <= woff;
        cnt_q  <= first ? pair_t'(1) : pair_t'(0);
      end
      if (load) latch_q <= load_val;
      if (clr)  cnt_q   <= '0;
    end
  end

  // R6: read counter is zero or one between accesses
  p_rd_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pair_t'(1));
  // R5: a second-half read (step without first) never coincides with a latch load
  p_second_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !first) |-> !load);
endmodule

// File: rtl/hwb_cfg_reg.sv
module hwb_cfg_reg import hwb_pkg::*; #(
  parameter logic [DW-1:0] CFG_BASE  = 32'h0005_0000,
  parameter logic [DW-1:0] CFG_WMASK = 32'h0003_F300,
  parameter int            MODE_BIT  = 2,
  parameter int            SRST_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode16,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_o,
  output logic          soft_rst_o
);
  localparam logic [DW-1:0] KEEP = DW'(1) << MODE_BIT;

  logic [DW-1:0] cfg_q;
  logic [DW-1:0] rst_val;

  assign rst_val    = cfg_reset(CFG_BASE, mode16, MODE_BIT);
  assign soft_rst_o = we && wdata[SRST_BIT];
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cfg_q <= rst_val;
    else if (soft_rst_o) cfg_q <= rst_val;
    else if (we)         cfg_q <= cfg_merge(cfg_q, wdata, CFG_WMASK, KEEP);
  end

  // R1: the bus-width bit always reports the strap
  p_mode_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[MODE_BIT] == !mode16);
  // R10: after an ordinary write nothing outside the mask and the mode bit survives
  p_cfg_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_rst_o) |=> ((cfg_q & ~(CFG_WMASK | KEEP)) == '0));
endmodule

// File: rtl/hw2w_bridge.sv
module hw2w_bridge import hwb_pkg::*; #(
  parameter int                HOST_AW   = 16,
  parameter int                OFF_W     = 8,
  parameter int                DS_AW     = 32,
  parameter logic [OFF_W-1:0]  CFG_OFF   = 8'h74,
  parameter logic [DW-1:0]     CFG_BASE  = 32'h0005_0000,
  parameter logic [DW-1:0]     CFG_WMASK = 32'h0003_F300,
  parameter int                MODE_BIT  = 2,
  parameter int                SRST_BIT  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode16,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [1:0]         host_size,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               host_ready,
  output logic               host_err,
  output logic               ds_req,
  output logic               ds_we,
  output logic [DS_AW-1:0]   ds_addr,
  output logic [DW-1:0]      ds_wdata,
  input  logic [DW-1:0]      ds_rdata
);
  bst_e             state_q;
  logic [OFF_W-1:0] off, woff;
  logic             upper, is_half, is_word, bad, hit_cfg, idle_req;
  logic             half_wr, half_rd, word_wr, word_rd;
  logic             fetch_any, fetch_ds, rd_first;
  logic             wr_commit, cfg_we, soft_rst, rd_load;
  logic [DW-1:0]    commit_word, cfg_val, cfg_wdata, rd_latch, word_q, fetch_src;
  logic             resp_half_q, resp_upper_q, src_cfg_q;
  pair_t            wr_cnt, rd_cnt;
  logic             addr_hi_unused;

  // Access decode: only the low offset bits matter.
  assign addr_hi_unused = ^host_addr[HOST_AW-1:OFF_W];
  assign off      = host_addr[OFF_W-1:0];
  assign woff     = {off[OFF_W-1:2], 2'b00};
  assign upper    = off[1];
  assign is_half  = (host_size == SZ_HALF);
  assign is_word  = (host_size == SZ_WORD);
  assign bad      = !(is_word || (is_half && mode16));
  assign hit_cfg  = (woff == CFG_OFF);
  assign idle_req = (state_q == ST_IDLE) && host_req;

  assign half_wr  = idle_req && !bad && is_half &&  host_we;
  assign half_rd  = idle_req && !bad && is_half && !host_we;
  assign word_wr  = idle_req && !bad && is_word &&  host_we;
  assign word_rd  = idle_req && !bad && is_word && !host_we;

  assign fetch_any = (half_rd && rd_first) || word_rd;
  assign fetch_ds  = fetch_any && !hit_cfg;

  hwb_wr_pair #(.OFF_W(OFF_W)) wr_pair_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (soft_rst),
    .step        (half_wr),
    .woff        (woff),
    .upper       (upper),
    .wdata16     (host_wdata[HW-1:0]),
    .commit      (wr_commit),
    .commit_word (commit_word),
    .cnt_o       (wr_cnt)
  );

  assign fetch_src = src_cfg_q ? cfg_val : ds_rdata;
  assign rd_load   = (state_q == ST_WAIT) && resp_half_q;

  hwb_rd_pair #(.OFF_W(OFF_W)) rd_pair_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_rst),
    .step     (half_rd),
    .woff     (woff),
    .load     (rd_load),
    .load_val (fetch_src),
    .first    (rd_first),
    .latch_o  (rd_latch),
    .cnt_o    (rd_cnt)
  );

  assign cfg_wdata = word_wr ? host_wdata : commit_word;
  assign cfg_we    = (word_wr || wr_commit) && hit_cfg;

  hwb_cfg_reg #(
    .CFG_BASE  (CFG_BASE),
    .CFG_WMASK (CFG_WMASK),
    .MODE_BIT  (MODE_BIT),
    .SRST_BIT  (SRST_BIT)
  ) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode16     (mode16),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .cfg_o      (cfg_val),
    .soft_rst_o (soft_rst)
  );

  // Downstream request: pass-through words, pair commits, fetches.
  assign ds_req   = fetch_ds || ((word_wr || wr_commit) && !hit_cfg);
  assign ds_we    = (word_wr || wr_commit) && !hit_cfg;
  assign ds_addr  = {{(DS_AW-OFF_W){1'b0}}, woff};
  assign ds_wdata = word_wr ? host_wdata : commit_word;

  // Fetch sequencer: IDLE -> WAIT (capture) -> RESP (ready).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      resp_half_q  <= 1'b0;
      resp_upper_q <= 1'b0;
      src_cfg_q    <= 1'b0;
      word_q       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fetch_any) begin
          state_q      <= ST_WAIT;
          resp_half_q  <= half_rd;
          resp_upper_q <= upper;
          src_cfg_q    <= hit_cfg;
        end
        ST_WAIT: begin
          state_q <= ST_RESP;
          if (!resp_half_q) word_q <= fetch_src;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign host_ready = (state_q == ST_IDLE) ? !fetch_any : (state_q == ST_RESP);
  assign host_err   = idle_req && bad;

  always_comb begin
    host_rdata = '0;
    if (state_q == ST_RESP)
      host_rdata = resp_half_q ? {{HW{1'b0}}, half_pick(rd_latch, resp_upper_q)} : word_q;
    else if (half_rd)
      host_rdata = {{HW{1'b0}}, half_pick(rd_latch, upper)};
  end

  // R9: an invalid access never reaches the register file
  p_err_no_ds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> !ds_req);
  // R9: an invalid access leaves both pair counters untouched
  p_err_keeps_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |=> ($stable(wr_cnt) && $stable(rd_cnt)));
  // R2: every downstream address is a word-aligned offset inside the window
  p_ds_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req |-> (ds_addr[1:0] == 2'b00 && ds_addr[DS_AW-1:OFF_W] == '0));
  // R12: a downstream read is followed by the capture cycle
  p_read_waits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && !ds_we) |=> (state_q == ST_WAIT && !host_ready));
  // R12: capture is followed by the ready response
  p_wait_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |=> host_ready);
endmodule

// File: tb/hw2w_bridge_tb_top.sv
`timescale 1ns/1ps
module hw2w_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode16 = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_size = 2'b00;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ready, host_err;
  logic        ds_req, ds_we;
  logic [31:0] ds_addr, ds_wdata;
  logic [31:0] ds_rdata = '0;

  int nchk = 0;
  int nfail = 0;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } ds_item_t;
  ds_item_t exp_q[$];

  logic [31:0] mem [0:63];

  always #2 clk = ~clk;

  hw2w_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .mode16(mode16),
    .host_req(host_req), .host_we(host_we), .host_size(host_size),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .host_err(host_err),
    .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Register file model plus scoreboard monitor.
  always @(posedge clk) begin
    if (rst_n && ds_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected register file access", ds_addr, 32'hFFFF_FFFF);
      end else begin
        ds_item_t it;
        it = exp_q.pop_front();
        chk(ds_we == it.we && ds_addr == it.addr && (!it.we || ds_wdata == it.data),
            it.req, it.we ? ds_wdata : ds_addr, it.we ? it.data : it.addr);
      end
      if (ds_we) mem[ds_addr[7:2]] <= ds_wdata;
      else       ds_rdata <= mem[ds_addr[7:2]];
    end
  end

  task automatic push_wr(input logic [31:0] a, input logic [31:0] d, input string req);
    ds_item_t it;
    it.we = 1'b1; it.addr = a; it.data = d; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic push_rd(input logic [31:0] a, input string req);
    ds_item_t it;
    it.we = 1'b0; it.addr = a; it.data = '0; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [15:0] a,
                        input logic [31:0] wd, input logic [31:0] exp_rd, input bit chk_rd,
                        input int exp_lat, input logic exp_err, input string req);
    int lat;
    bit done;
    logic [31:0] rd;
    logic er;
    lat = 0; done = 0; rd = '0; er = 1'b0;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_size = sz; host_addr = a; host_wdata = wd;
    while (!done) begin
      #1;
      if (host_ready) begin
        rd = host_rdata; er = host_err; done = 1;
        @(posedge clk);
        #1 host_req = 1'b0;
      end else begin
        @(posedge clk);
        lat++;
        @(negedge clk);
      end
    end
    chk(lat == exp_lat, req, lat, exp_lat);
    chk(er == exp_err, req, {31'b0, er}, {31'b0, exp_err});
    if (chk_rd) chk(rd == exp_rd, req, rd, exp_rd);
  endtask

  task automatic do_reset(input logic m16);
    @(negedge clk);
    rst_n = 1'b0; mode16 = m16;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R12 watchdog expired", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;

    // ---- 32-bit mode ----
    do_reset(1'b0);
    access(0, 2'b10, 16'h0074, 0, 32'h0005_0004, 1, 2, 0, "R1 cfg reset 32-bit");
    access(1, 2'b01, 16'h0020, 32'h1234, 0, 0, 0, 1, "R9 half write in 32-bit mode");
    access(0, 2'b01, 16'h0020, 0, 0, 0, 0, 1, "R9 half read in 32-bit mode");
    push_wr(32'h10, 32'hA5A5_0001, "R8 word write pass-through");
    access(1, 2'b10, 16'h0010, 32'hA5A5_0001, 0, 0, 0, 0, "R8 word write");
    push_rd(32'h10, "R8 word read pass-through");
    access(0, 2'b10, 16'h0010, 0, 32'hA5A5_0001, 1, 2, 0, "R8 word read");
    push_wr(32'h10, 32'h0BAD_F00D, "R2 upper address bits ignored");
    access(1, 2'b10, 16'h3F10, 32'h0BAD_F00D, 0, 0, 0, 0, "R2 upper bits");
    push_wr(32'h10, 32'h1234_5678, "R2 low bits cleared");
    access(1, 2'b10, 16'h0013, 32'h1234_5678, 0, 0, 0, 0, "R2 unaligned word");
    access(1, 2'b10, 16'h0074, 32'h0000_0000, 0, 0, 0, 0, "R10 cfg write zero");
    access(0, 2'b10, 16'h0074, 0, 32'h0000_0004, 1, 2, 0, "R10 mode bit kept");

    // ---- 16-bit mode ----
    do_reset(1'b1);
    access(0, 2'b10, 16'h0074, 0, 32'h0005_0000, 1, 2, 0, "R1 cfg reset 16-bit");
    access(1, 2'b01, 16'h0020, 32'h1111, 0, 0, 0, 0, "R3 first half no write");
    push_wr(32'h20, 32'h2222_1111, "R3 pair commit");
    access(1, 2'b01, 16'h0022, 32'h2222, 0, 0, 0, 0, "R3 second half");
    access(1, 2'b01, 16'h0030, 32'hAAAA, 0, 0, 0, 0, "R4 orphan half");
    access(1, 2'b01, 16'h0040, 32'hBBBB, 0, 0, 0, 0, "R4 new word restarts");
    push_wr(32'h40, 32'hCCCC_BBBB, "R4 commit at new word");
    access(1, 2'b01, 16'h0042, 32'hCCCC, 0, 0, 0, 0, "R4 pair at 0x40");
    access(1, 2'b01, 16'h0050, 32'h1234, 0, 0, 0, 0, "R4 low half");
    push_wr(32'h50, 32'hCCCC_5678, "R4 two low halves");
    access(1, 2'b01, 16'h0050, 32'h5678, 0, 0, 0, 0, "R4 repeated low half");

    push_rd(32'h20, "R5 first half fetch");
    access(0, 2'b01, 16'h0022, 0, 32'h0000_2222, 1, 2, 0, "R5 upper half fetched");
    @(negedge clk); mem[8] = 32'hDEAD_BEEF;
    access(0, 2'b01, 16'h0020, 0, 32'h0000_1111, 1, 0, 0, "R5 second half from latch");
    push_rd(32'h20, "R5 next pair fetch");
    access(0, 2'b01, 16'h0020, 0, 32'h0000_BEEF, 1, 2, 0, "R5 new pair sees update");

    push_rd(32'h40, "R6 fetch 0x40");
    access(0, 2'b01, 16'h0040, 0, 32'h0000_BBBB, 1, 2, 0, "R6 read 0x40");
    push_rd(32'h50, "R6 word moved refetch");
    access(0, 2'b01, 16'h0050, 0, 32'h0000_5678, 1, 2, 0, "R6 read 0x50");
    access(0, 2'b01, 16'h0052, 0, 32'h0000_CCCC, 1, 0, 0, "R6 second half 0x52");

    access(1, 2'b01, 16'h0060, 32'h0101, 0, 0, 0, 0, "R7 write half");
    push_rd(32'h10, "R7 interleaved read");
    access(0, 2'b01, 16'h0010, 0, 32'h0000_5678, 1, 2, 0, "R7 read between halves");
    push_wr(32'h60, 32'h0202_0101, "R7 write pair survives");
    access(1, 2'b01, 16'h0062, 32'h0202, 0, 0, 0, 0, "R7 write second half");
    access(0, 2'b01, 16'h0012, 0, 32'h0000_1234, 1, 0, 0, "R7 read pair survives");

    access(1, 2'b01, 16'h0070, 32'h7777, 0, 0, 0, 0, "R8 half before word");
    push_wr(32'h70, 32'hFEED_FACE, "R8 word in 16-bit mode");
    access(1, 2'b10, 16'h0070, 32'hFEED_FACE, 0, 0, 0, 0, "R8 word between halves");
    push_wr(32'h70, 32'h8888_7777, "R8 pair unaffected by word");
    access(1, 2'b01, 16'h0072, 32'h8888, 0, 0, 0, 0, "R8 completing half");

    access(1, 2'b00, 16'h0080, 32'h1, 0, 0, 0, 1, "R9 size 00");
    access(1, 2'b01, 16'h0084, 32'h4444, 0, 0, 0, 0, "R9 half before error");
    access(0, 2'b11, 16'h0090, 0, 0, 0, 0, 1, "R9 size 11");
    push_wr(32'h84, 32'h5555_4444, "R9 counters kept over error");
    access(1, 2'b01, 16'h0086, 32'h5555, 0, 0, 0, 0, "R9 completing half");

    access(1, 2'b10, 16'h0074, 32'hFFFF_FFFE, 0, 0, 0, 0, "R10 cfg write mask");
    access(0, 2'b10, 16'h0074, 0, 32'h0003_F300, 1, 2, 0, "R10 cfg readback");
    access(1, 2'b01, 16'h0076, 32'h0001, 0, 0, 0, 0, "R10 cfg high half");
    access(1, 2'b01, 16'h0074, 32'h0000, 0, 0, 0, 0, "R10 cfg low half");
    access(0, 2'b01, 16'h0074, 0, 32'h0000_0000, 1, 2, 0, "R10 cfg half read low");
    access(0, 2'b01, 16'h0076, 0, 32'h0000_0001, 1, 0, 0, "R10 cfg half read high");

    access(1, 2'b01, 16'h0090, 32'h9999, 0, 0, 0, 0, "R11 pending write half");
    push_rd(32'h10, "R11 pending read half");
    access(0, 2'b01, 16'h0010, 0, 32'h0000_5678, 1, 2, 0, "R11 read before reset");
    access(1, 2'b10, 16'h0074, 32'h0000_0001, 0, 0, 0, 0, "R11 soft reset");
    access(0, 2'b10, 16'h0074, 0, 32'h0005_0000, 1, 2, 0, "R11 cfg restored");
    access(1, 2'b01, 16'h0092, 32'h9191, 0, 0, 0, 0, "R11 write counter cleared");
    push_wr(32'h90, 32'h9191_9292, "R11 fresh write pair");
    access(1, 2'b01, 16'h0090, 32'h9292, 0, 0, 0, 0, "R11 completing half");
    push_rd(32'h10, "R11 read counter cleared");
    access(0, 2'b01, 16'h0012, 0, 32'h0000_1234, 1, 2, 0, "R11 refetch after reset");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 pending register file accesses", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule